// File: doc/BRIEF.md
# Flash Protection-Bit Command Controller

This block is the command front end that sets the per-block write/erase protection bits of an on-chip flash array. Software issues a fixed unlock pattern of six bus writes, then a seventh write whose address carries the index of the block to protect. From that seventh write the controller reports busy while a programmable cycle counter stands in for the cell programming time. When the counter runs out, the selected protection bit is set and the controller reports ready again.

The block also checks erase requests. An erase aimed at a protected block is never passed on, nor is one made while the block is busy or locked. If the array reports a failed erase, the controller locks: it reports not-ready and ignores every command until a hardware reset. A hardware reset aborts programming and clears the decoder, but keeps the protection bits that already completed. Those bits are cleared only by a separate power-on clear that models a fresh array.

Top module: `flash_prot_cmd`

## Requirements
- R1: After power-on clear and hardware reset, `ready` is 1, `prot_status` is all zeros, `locked` is 0 and `erase_go` is 0.
- R2: Six writes matching the unlock pattern in order, then a seventh write with data `CONF_DATA` and an in-range index in `addr[IDX_LSB +: IDX_W]`, drive `ready` to 0 from the cycle after the seventh write. `ready` stays 0 for exactly `PROG_CYCLES` cycles, then returns to 1 with bit `index` of `prot_status` set.
- R3: A write that does not match the expected unlock step (address or data) returns the decoder to its first step, so the rest of that attempt programs nothing.
- R4: A read strobe (`rd_en`) between unlock writes returns the decoder to its first step.
- R5: A seventh write whose index is `NBLK` or larger starts no programming: `ready` stays 1 and `prot_status` is unchanged.
- R6: While busy, writes are ignored. A complete sequence issued during busy programs no second block.
- R7: `sw_reset` has no effect while busy or when it coincides with the seventh write. When idle it returns a partial sequence to the first step.
- R8: A hardware reset during busy returns `ready` to 1 at once. The interrupted bit stays 0 and bits set earlier are kept.
- R9: `erase_req` for block `erase_blk` gives `erase_go` = 1 on the next cycle only if that block is unprotected and the controller is ready. Otherwise `erase_go` stays 0.
- R10: `erase_fail` sets `locked` and drives `ready` to 0. Commands and erases are then ignored until a hardware reset clears the lock.
- R11: Once every block has been protected, `prot_status` reads all ones and every erase request is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on clear of the protection bits, active low |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | AW | Bus address |
| wdata | input | DW | Bus write data |
| sw_reset | input | 1 | Software reset command |
| erase_req | input | 1 | Erase request |
| erase_blk | input | BW | Block targeted by the erase request |
| erase_fail | input | 1 | Erase failure report from the array |
| erase_go | output | 1 | Erase permitted, one cycle after the request |
| ready | output | 1 | 1 = ready, 0 = busy or locked |
| locked | output | 1 | Erase-failure lockout |
| prot_status | output | NBLK | Protection bit per block |

## Verification
The decoder is driven with random mixes of four kinds of attempt, and each kind isolates one path. A clean sequence to a random index, some out of range, tells valid launches from ignored indices. The same sequence with one corrupted step at a random position shows whether every position is compared. A read inserted mid-sequence and a software reset inserted mid-sequence confirm the decoder restarts from its first step. Directed cases then probe the behaviour at the edges of the busy window: a command issued during busy, a software reset alongside the seventh write, a hardware reset mid-programming, the lockout after an erase failure, and erases refused once every block is protected.

// File: rtl/flash_prot_cmd.sv
module flash_prot_cmd #(
  parameter int NBLK        = 4,
  parameter int AW          = 16,
  parameter int DW          = 8,
  parameter int IDX_LSB     = 8,
  parameter int IDX_W       = 4,
  parameter int PROG_CYCLES = 20,
  parameter logic [6*AW-1:0] UNLK_ADDR = {16'h0555, 16'h02AA, 16'h0555,
                                          16'h0555, 16'h02AA, 16'h0555},
  parameter logic [6*DW-1:0] UNLK_DATA = {8'h10, 8'h55, 8'hAA,
                                          8'h80, 8'h55, 8'hAA},
  parameter logic [DW-1:0]   CONF_DATA = 8'h6A,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic            sw_reset,
  input  logic            erase_req,
  input  logic [BW-1:0]   erase_blk,
  input  logic            erase_fail,
  output logic            erase_go,
  output logic            ready,
  output logic            locked,
  output logic [NBLK-1:0] prot_status
);

  localparam int TW = $clog2(PROG_CYCLES + 1);
  localparam logic [IDX_W:0] NB = (IDX_W + 1)'(NBLK);
  localparam logic [BW:0]    NE = (BW + 1)'(NBLK);

  logic [2:0]      step;
  logic            busy;
  logic [TW-1:0]   tmr;
  logic [BW-1:0]   tgt;
  logic [NBLK-1:0] prot;

  wire [IDX_W-1:0] sel     = addr[IDX_LSB +: IDX_W];
  wire [2:0]       pi      = (step < 3'd6) ? step : 3'd0;
  wire             idle_ok = !busy && !locked;
  wire             pat_hit = (step < 3'd6) &&
                             (addr  == UNLK_ADDR[pi*AW +: AW]) &&
                             (wdata == UNLK_DATA[pi*DW +: DW]);
  wire             launch  = wr_en && idle_ok && (step == 3'd6) &&
                             (wdata == CONF_DATA) && ({1'b0, sel} < NB);
  wire             done    = busy && (tmr == '0);

  assign ready       = idle_ok;
  assign prot_status = prot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step <= '0;
    else if (!idle_ok) step <= '0;
    else if (wr_en) step <= pat_hit ? step + 3'd1 : 3'd0;
    else if (sw_reset || rd_en) step <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tmr  <= '0;
      tgt  <= '0;
    end else if (launch) begin
      busy <= 1'b1;
      tmr  <= TW'(PROG_CYCLES - 1);
      tgt  <= sel[BW-1:0];
    end else if (busy) begin
      if (tmr == '0) busy <= 1'b0;
      else tmr <= tmr - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) prot <= '0;
    else if (done) prot[tgt] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locked <= 1'b0;
    else if (erase_fail) locked <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) erase_go <= 1'b0;
    else erase_go <= erase_req && idle_ok && ({1'b0, erase_blk} < NE) &&
                     !prot[erase_blk];
  end

  // R2
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !ready);

  // R6
  busy_decoder_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> step == 3'd0);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tmr != '0) |=> busy);

  // R8
  prot_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
    (prot & $past(prot)) == $past(prot));

  // R9
  erase_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_go) |-> $past(erase_req) && !prot[$past(erase_blk)]);

  // R10
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked && !ready);

endmodule

// File: tb/flash_prot_cmd_test.sv
module flash_prot_cmd_test;
  localparam int NBLK = 4;
  localparam int PROG = 20;
  localparam logic [15:0] PA [6] = '{16'h0555, 16'h02AA, 16'h0555,
                                     16'h0555, 16'h02AA, 16'h0555};
  localparam logic [7:0]  PD [6] = '{8'hAA, 8'h55, 8'h80,
                                     8'hAA, 8'h55, 8'h10};
  localparam logic [7:0]  CONF = 8'h6A;

  logic clk = 0, por_n = 0, rst_n = 0, wr_en = 0, rd_en = 0, sw_reset = 0;
  logic [15:0] addr = 0;
  logic [7:0] wdata = 0;
  logic erase_req = 0, erase_fail = 0;
  logic [1:0] erase_blk = 0;
  logic erase_go, ready, locked;
  logic [NBLK-1:0] prot_status;
  logic [NBLK-1:0] mprot;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flash_prot_cmd uut (.clk, .por_n, .rst_n, .wr_en, .rd_en, .addr, .wdata,
    .sw_reset, .erase_req, .erase_blk, .erase_fail, .erase_go, .ready,
    .locked, .prot_status);

  function automatic bit exp_launch(int mode, int idx);
    return mode == 0 && idx < NBLK;
  endfunction

  function automatic logic [NBLK-1:0] exp_prot(logic [NBLK-1:0] p, int idx, bit go);
    if (go) p[idx] = 1'b1;
    return p;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d, bit sw = 0);
    @(negedge clk); wr_en = 1; addr = a; wdata = d; sw_reset = sw;
    @(negedge clk); wr_en = 0; sw_reset = 0;
  endtask

  task automatic pulse_rd(); @(negedge clk); rd_en = 1; @(negedge clk); rd_en = 0; endtask
  task automatic pulse_sw(); @(negedge clk); sw_reset = 1; @(negedge clk); sw_reset = 0; endtask

  // mode 0 clean, 1 corrupt at pos, 2 read before pos, 3 sw_reset before pos
  task automatic send_seq(int idx, int mode, int pos, bit sw7 = 0);
    for (int i = 0; i < 6; i++) begin
      if (mode != 0 && i == pos) begin
        if (mode == 1) begin wr(PA[i], PD[i] ^ 8'h01); continue; end
        else if (mode == 2) pulse_rd();
        else pulse_sw();
      end
      wr(PA[i], PD[i]);
    end
    wr(16'(idx) << 8, CONF, sw7);
  endtask

  task automatic hw_reset();
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
  endtask

  task automatic full_clear();
    @(negedge clk); por_n = 0; rst_n = 0;
    @(negedge clk); por_n = 1; rst_n = 1;
    mprot = '0;
  endtask

  task automatic expect_program(string req, int idx);
    check(req, ready, 0);
    repeat (PROG - 1) @(negedge clk);
    check(req, ready, 0);
    @(negedge clk);
    mprot = exp_prot(mprot, idx, 1);
    check(req, ready, 1);
    check(req, prot_status, mprot);
  endtask

  task automatic erase(int b, bit exp);
    @(negedge clk); erase_req = 1; erase_blk = 2'(b);
    @(negedge clk); erase_req = 0;
    check("R9 erase_go", erase_go, exp);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mprot = '0;
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    @(negedge clk);
    check("R1 ready", ready, 1);
    check("R1 prot", prot_status, 0);
    check("R1 locked", locked, 0);
    check("R1 erase_go", erase_go, 0);

    // random mix: R2 R3 R4 R5 R7
    for (int n = 0; n < 60; n++) begin
      int mode, idx, pos;
      if (n % 12 == 0) full_clear();
      mode = int'($urandom % 4);
      idx  = int'($urandom % 8);
      pos  = (mode == 1) ? int'($urandom % 6) : 1 + int'($urandom % 5);
      send_seq(idx, mode, pos);
      if (exp_launch(mode, idx)) expect_program("R2 random", idx);
      else begin
        @(negedge clk);
        check(mode == 0 ? "R5 range" : (mode == 1 ? "R3 corrupt" :
              (mode == 2 ? "R4 read" : "R7 sw idle")), ready, 1);
        check("R3/R4/R5 prot", prot_status, mprot);
      end
    end

    // R5 directed
    full_clear();
    send_seq(NBLK, 0, 0);
    check("R5 ready", ready, 1);
    check("R5 prot", prot_status, 0);

    // R6 + R7 seventh write with sw_reset, sw_reset during busy
    send_seq(0, 0, 0, 1);
    check("R7 sw on seventh", ready, 0);
    pulse_sw();
    send_seq(1, 0, 0);
    repeat (PROG - 17) @(negedge clk);
    check("R7 busy", ready, 0);
    @(negedge clk);
    check("R6 ready", ready, 1);
    check("R6 prot", prot_status, 4'b0001);
    repeat (PROG + 4) @(negedge clk);
    check("R6 no second", prot_status, 4'b0001);
    mprot = 4'b0001;

    // R9
    erase(0, 0);
    erase(3, 1);

    // R8
    send_seq(2, 0, 0);
    repeat (5) @(negedge clk);
    hw_reset();
    check("R8 ready", ready, 1);
    check("R8 prot", prot_status, 4'b0001);
    repeat (PROG) @(negedge clk);
    check("R8 bit stays clear", prot_status, 4'b0001);

    // R10
    @(negedge clk); erase_fail = 1; @(negedge clk); erase_fail = 0;
    check("R10 locked", locked, 1);
    check("R10 ready", ready, 0);
    send_seq(2, 0, 0);
    repeat (PROG + 2) @(negedge clk);
    check("R10 ignored", prot_status, 4'b0001);
    erase(3, 0);
    hw_reset();
    check("R10 unlock", locked, 0);
    check("R10 ready back", ready, 1);

    // R11
    for (int b = 1; b < NBLK; b++) begin
      send_seq(b, 0, 0);
      expect_program("R11 program", b);
    end
    check("R11 all set", prot_status, 4'b1111);
    for (int b = 0; b < NBLK; b++) erase(b, 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule